// File: doc/BRIEF.md
# Dynamic Range Enhancer Gain Controller

This block is a digital gain controller for a multi-channel audio record path. For each channel it watches the level of incoming samples, taken after the analog front-end amplifier. While the signal stays quiet it steps the analog boost up in 2 dB increments. The boost is passed to the amplifier as a gain code. The controller then scales each sample by the inverse gain, so the overall channel gain stays at 0 dB. When a sample gets loud it drops the boost to zero in one step, so the converter is not driven into clipping.

A shared configuration port sets three things: the trigger level, the largest boost allowed, and the number of quiet samples needed before each step. This port is honoured only while the device is powered down. Reserved codes fall back to their reset values and set a sticky error flag. Each channel has its own enable. The whole function turns off while the output sample rate is above 192 kHz. A channel that is off passes its samples through unchanged at zero boost.

The digital compensation follows the boost through a delay of `LAT` samples. This delay models the time the analog gain change takes to reach the sample stream, so the analog and digital gain changes meet on the same sample.

Top module: `dre_gain_ctrl`

## Requirements
- R1: After reset, `again_o` is 0 for every channel, `out_valid_o` is 0 and `cfg_err_o` is 0. The trigger code resets to 7 (-54 dB), the maximum-gain code resets to 11 (12 steps, 24 dB) and the hold count resets to `HOLD_RST`.
- R2: A channel whose bit in `ch_en_i` is 0 reports an `again_o` field of 0. Its output sample equals its input sample.
- R3: Trigger code k (0..9) sets a magnitude limit of 2^(SW-1) >> (k+2), about -12-6k dBFS. Each valid sample whose compensated magnitude is below this limit counts as quiet. After `hold` consecutive quiet samples, the channel's 4-bit boost field in `again_o` rises by 1 (one 2 dB step) and the count restarts.
- R4: Maximum-gain code n (0..14) caps the boost at n+1 steps, which is 2(n+1) dB.
- R5: When a valid sample's compensated magnitude exceeds the limit while the boost is above 0, the boost returns to 0 on the next clock.
- R6: For a sample accepted with `smp_valid_i`, `out_valid_o` and `out_data_o` are updated one clock later. The output is floor(x*C(s)/32768), where C(s) = round(32768*10^(-s/10)). Here s is the boost value that held after the sample `LAT` valid samples earlier.
- R7: Configuration writes made while `power_up_i` is 1 have no effect.
- R8: A reserved trigger code (10..15) is stored as 7, and a reserved maximum-gain code (15) is stored as 11. Either one sets `cfg_err_o`, which stays set until reset.
- R9: While `rate_hi_i` is 1, or `power_up_i` is 0, every channel behaves as disabled. Its boost and delay state are cleared.
- R10: `again_o` changes only on the clock after a valid sample of that channel, or when the channel's active state changes. It changes by at most one step up per sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_thr_i | input | 4 | Trigger level code |
| cfg_max_i | input | 4 | Maximum boost code |
| cfg_hold_i | input | HOLD_W | Quiet samples needed per boost step |
| power_up_i | input | 1 | Device powered up; locks configuration |
| rate_hi_i | input | 1 | Output sample rate above 192 kHz |
| ch_en_i | input | NUM_CH | Per-channel enable |
| smp_valid_i | input | NUM_CH | Per-channel sample strobe |
| smp_data_i | input | NUM_CH*SW | Signed input samples, channel c at bits [c*SW +: SW] |
| again_o | output | NUM_CH*4 | Analog boost code in 2 dB steps, channel c at [c*4 +: 4] |
| out_valid_o | output | NUM_CH | Compensated sample strobe |
| out_data_o | output | NUM_CH*SW | Compensated signed samples |
| cfg_err_o | output | 1 | Sticky reserved-code flag |

## Verification
The hardest situation to reach is a release that happens while the compensation delay line still holds an older, different boost. In that case the output scaling and the loudness decision both depend on a gain from `LAT` samples back. The stimulus gets there with a very short hold count and a reserved maximum-gain code, which lets the boost climb to 12 steps quickly. A loud sample then arrives just as the cap is reached. A few more quiet samples follow, so the zeros make their way through the delay line while the scoreboard checks every compensated word. Configuration writes made while powered up are checked through the cap and the step timing that follow them.

// File: rtl/dre_pkg.sv
package dre_pkg;
  localparam int BOOST_W = 4;
  localparam int CODE_W  = 4;
  localparam int COEF_W  = 17;

  localparam logic [CODE_W-1:0] THR_RST  = 4'd7;
  localparam logic [CODE_W-1:0] THR_LAST = 4'd9;
  localparam logic [CODE_W-1:0] MAX_RST  = 4'd11;
  localparam logic [CODE_W-1:0] MAX_LAST = 4'd14;

  // Q1.15 attenuation for s steps of 2 dB: round(32768 * 10^(-s/10))
  function automatic logic [COEF_W-1:0] comp_coef(input logic [BOOST_W-1:0] s);
    logic [COEF_W-1:0] c;
    case (s)
      4'd0:    c = 17'd32768;
      4'd1:    c = 17'd26029;
      4'd2:    c = 17'd20675;
      4'd3:    c = 17'd16423;
      4'd4:    c = 17'd13045;
      4'd5:    c = 17'd10362;
      4'd6:    c = 17'd8231;
      4'd7:    c = 17'd6538;
      4'd8:    c = 17'd5193;
      4'd9:    c = 17'd4125;
      4'd10:   c = 17'd3277;
      4'd11:   c = 17'd2603;
      4'd12:   c = 17'd2068;
      4'd13:   c = 17'd1642;
      4'd14:   c = 17'd1305;
      default: c = 17'd1036;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/dre_cfg.sv
module dre_cfg
  import dre_pkg::*;
#(
  parameter int HOLD_W   = 8,
  parameter int HOLD_RST = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CODE_W-1:0] thr_i,
  input  logic [CODE_W-1:0] max_i,
  input  logic [HOLD_W-1:0] hold_i,
  input  logic              power_up_i,
  output logic [CODE_W-1:0] thr_o,
  output logic [CODE_W-1:0] max_o,
  output logic [HOLD_W-1:0] hold_o,
  output logic              err_o
);
  logic thr_bad, max_bad, wr_ok;

  assign thr_bad = thr_i > THR_LAST;
  assign max_bad = max_i > MAX_LAST;
  assign wr_ok   = we_i && !power_up_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_o  <= THR_RST;
      max_o  <= MAX_RST;
      hold_o <= HOLD_W'(HOLD_RST);
      err_o  <= 1'b0;
    end else if (wr_ok) begin
      thr_o  <= thr_bad ? THR_RST : thr_i;
      max_o  <= max_bad ? MAX_RST : max_i;
      hold_o <= hold_i;
      if (thr_bad || max_bad) err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/dre_comp.sv
module dre_comp
  import dre_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic signed [SW-1:0]      data_i,
  input  logic        [BOOST_W-1:0] step_i,
  output logic signed [SW-1:0]      data_o
);
  localparam int PW = SW + COEF_W + 1;

  logic signed [PW-1:0] prod;

  assign prod   = PW'(data_i) * PW'($signed({1'b0, comp_coef(step_i)}));
  // coefficient never exceeds 1.0, so the scaled value fits SW bits
  assign data_o = SW'(prod >>> 15);
endmodule

// File: rtl/dre_chan.sv
module dre_chan
  import dre_pkg::*;
#(
  parameter int SW     = 16,
  parameter int HOLD_W = 8,
  parameter int LAT    = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 active_i,
  input  logic                 valid_i,
  input  logic [SW-1:0]        data_i,
  input  logic [SW-1:0]        thr_mag_i,
  input  logic [BOOST_W-1:0]   max_steps_i,
  input  logic [HOLD_W-1:0]    hold_i,
  output logic [BOOST_W-1:0]   again_o,
  output logic                 valid_o,
  output logic [SW-1:0]        data_o
);
  logic [BOOST_W-1:0] boost_q, boost_d;
  logic [HOLD_W-1:0]  cnt_q, cnt_d;
  logic [HOLD_W:0]    cnt_inc;
  logic [BOOST_W-1:0] dly_q [LAT];
  logic [BOOST_W-1:0] step_app;
  logic [SW-1:0]      comp_y, mag;
  logic               quiet, loud;

  assign step_app = active_i ? dly_q[LAT-1] : '0;

  dre_comp #(.SW(SW)) u_comp (
    .data_i (data_i),
    .step_i (step_app),
    .data_o (comp_y)
  );

  assign mag     = comp_y[SW-1] ? (~comp_y + 1'b1) : comp_y;
  assign quiet   = mag < thr_mag_i;
  assign loud    = mag > thr_mag_i;
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    boost_d = boost_q;
    cnt_d   = cnt_q;
    if (quiet) begin
      if (cnt_inc >= {1'b0, hold_i}) begin
        cnt_d = '0;
        if (boost_q < max_steps_i) boost_d = boost_q + 1'b1;
      end else begin
        cnt_d = cnt_inc[HOLD_W-1:0];
      end
    end else begin
      cnt_d = '0;
      if (loud) boost_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boost_q <= '0;
      cnt_q   <= '0;
      for (int i = 0; i < LAT; i++) dly_q[i] <= '0;
    end else if (!active_i) begin
      boost_q <= '0;
      cnt_q   <= '0;
      for (int i = 0; i < LAT; i++) dly_q[i] <= '0;
    end else if (valid_i) begin
      boost_q  <= boost_d;
      cnt_q    <= cnt_d;
      dly_q[0] <= boost_d;
      for (int i = 1; i < LAT; i++) dly_q[i] <= dly_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= comp_y;
    end
  end

  assign again_o = active_i ? boost_q : '0;
endmodule

// File: rtl/dre_gain_ctrl.sv
module dre_gain_ctrl
  import dre_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int SW       = 16,
  parameter int HOLD_W   = 8,
  parameter int HOLD_RST = 16,
  parameter int LAT      = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_we_i,
  input  logic [3:0]             cfg_thr_i,
  input  logic [3:0]             cfg_max_i,
  input  logic [HOLD_W-1:0]      cfg_hold_i,
  input  logic                   power_up_i,
  input  logic                   rate_hi_i,
  input  logic [NUM_CH-1:0]      ch_en_i,
  input  logic [NUM_CH-1:0]      smp_valid_i,
  input  logic [NUM_CH*SW-1:0]   smp_data_i,
  output logic [NUM_CH*4-1:0]    again_o,
  output logic [NUM_CH-1:0]      out_valid_o,
  output logic [NUM_CH*SW-1:0]   out_data_o,
  output logic                   cfg_err_o
);
  logic [CODE_W-1:0]  thr_code, max_code;
  logic [HOLD_W-1:0]  hold_cnt;
  logic [SW-1:0]      thr_mag;
  logic [BOOST_W-1:0] max_steps;
  logic               fn_on;

  dre_cfg #(.HOLD_W(HOLD_W), .HOLD_RST(HOLD_RST)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .thr_i      (cfg_thr_i),
    .max_i      (cfg_max_i),
    .hold_i     (cfg_hold_i),
    .power_up_i (power_up_i),
    .thr_o      (thr_code),
    .max_o      (max_code),
    .hold_o     (hold_cnt),
    .err_o      (cfg_err_o)
  );

  assign thr_mag   = {1'b1, {(SW-1){1'b0}}} >> ({1'b0, thr_code} + 5'd2);
  assign max_steps = max_code + 1'b1;
  assign fn_on     = power_up_i && !rate_hi_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dre_chan #(.SW(SW), .HOLD_W(HOLD_W), .LAT(LAT)) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .active_i    (fn_on && ch_en_i[c]),
      .valid_i     (smp_valid_i[c]),
      .data_i      (smp_data_i[c*SW +: SW]),
      .thr_mag_i   (thr_mag),
      .max_steps_i (max_steps),
      .hold_i      (hold_cnt),
      .again_o     (again_o[c*4 +: 4]),
      .valid_o     (out_valid_o[c]),
      .data_o      (out_data_o[c*SW +: SW])
    );
  end
endmodule

// File: rtl/dre_gain_ctrl_chk.sv
module dre_gain_ctrl_chk #(
  parameter int NUM_CH = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                power_up_i,
  input logic                rate_hi_i,
  input logic [NUM_CH-1:0]   ch_en_i,
  input logic [NUM_CH-1:0]   smp_valid_i,
  input logic [NUM_CH*4-1:0] again_o,
  input logic [NUM_CH-1:0]   out_valid_o,
  input logic                cfg_err_o,
  input logic [3:0]          thr_code,
  input logic [3:0]          max_code
);
  AST_OUT_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == $past(smp_valid_i)); // R6

  AST_CFG_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(power_up_i) |-> ($stable(thr_code) && $stable(max_code))); // R7

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_err_o) |-> cfg_err_o); // R8

  AST_CODES_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_code <= 4'd9) && (max_code <= 4'd14)); // R8

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (again_o[c*4 +: 4] > $past(again_o[c*4 +: 4])) |->
        (again_o[c*4 +: 4] == $past(again_o[c*4 +: 4]) + 4'd1)); // R10

    AST_DROP_TO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (again_o[c*4 +: 4] < $past(again_o[c*4 +: 4])) |-> (again_o[c*4 +: 4] == 4'd0)); // R5

    AST_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      again_o[c*4 +: 4] <= max_code + 4'd1); // R4

    AST_OFF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!power_up_i || rate_hi_i || !ch_en_i[c]) |-> (again_o[c*4 +: 4] == 4'd0)); // R9

    AST_CHANGE_ON_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$past(smp_valid_i[c]) && $stable(power_up_i) && $stable(rate_hi_i) &&
       $stable(ch_en_i[c])) |-> $stable(again_o[c*4 +: 4])); // R10
  end
endmodule

bind dre_gain_ctrl dre_gain_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .power_up_i  (power_up_i),
  .rate_hi_i   (rate_hi_i),
  .ch_en_i     (ch_en_i),
  .smp_valid_i (smp_valid_i),
  .again_o     (again_o),
  .out_valid_o (out_valid_o),
  .cfg_err_o   (cfg_err_o),
  .thr_code    (thr_code),
  .max_code    (max_code)
);

// File: tb/dre_gain_ctrl_bench.sv
module dre_gain_ctrl_bench;
  localparam int NUM_CH = 2;
  localparam int SW     = 16;
  localparam int HOLD_W = 8;
  localparam int HOLD_RST = 16;
  localparam int LAT    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_thr = '0, cfg_max = '0;
  logic [HOLD_W-1:0] cfg_hold = '0;
  logic pw = 1'b0, rate_hi = 1'b0;
  logic [NUM_CH-1:0] ch_en = '0, s_valid = '0;
  logic [NUM_CH*SW-1:0] s_data = '0;
  logic [NUM_CH*4-1:0] again;
  logic [NUM_CH-1:0] o_valid;
  logic [NUM_CH*SW-1:0] o_data;
  logic cfg_err;

  always #2 clk = ~clk;

  dre_gain_ctrl #(.NUM_CH(NUM_CH), .SW(SW), .HOLD_W(HOLD_W), .HOLD_RST(HOLD_RST), .LAT(LAT))
  u_dre_gain_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_thr_i(cfg_thr),
    .cfg_max_i(cfg_max), .cfg_hold_i(cfg_hold), .power_up_i(pw), .rate_hi_i(rate_hi),
    .ch_en_i(ch_en), .smp_valid_i(s_valid), .smp_data_i(s_data), .again_o(again),
    .out_valid_o(o_valid), .out_data_o(o_data), .cfg_err_o(cfg_err)
  );

  int n_tests = 0, n_fail = 0;
  int m_thr = 7, m_max = 11, m_hold = HOLD_RST, m_err = 0;
  int mb[NUM_CH], mcnt[NUM_CH];
  int mdl[NUM_CH][LAT];
  int exp0[$], exp1[$];
  string tag0[$], tag1[$];

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint coef(int s);
    return longint'($rtoi(32768.0 * (10.0 ** (-s / 10.0)) + 0.5));
  endfunction

  function automatic bit is_act(int c);
    return pw && !rate_hi && ch_en[c];
  endfunction

  task automatic model_clear(int c);
    mb[c] = 0; mcnt[c] = 0;
    for (int i = 0; i < LAT; i++) mdl[c][i] = 0;
  endtask

  task automatic model_step(int c, int x, string tag);
    int ap, y, mag, thr;
    ap  = is_act(c) ? mdl[c][LAT-1] : 0;
    y   = int'((longint'(x) * coef(ap)) >>> 15);
    if (c == 0) begin exp0.push_back(y); tag0.push_back(tag); end
    else begin exp1.push_back(y); tag1.push_back(tag); end
    if (!is_act(c)) begin model_clear(c); return; end
    mag = (y < 0) ? -y : y;
    thr = 32768 >> (m_thr + 2);
    if (mag < thr) begin
      mcnt[c]++;
      if (mcnt[c] >= m_hold) begin
        mcnt[c] = 0;
        if (mb[c] < m_max + 1) mb[c]++;
      end
    end else begin
      mcnt[c] = 0;
      if (mag > thr) mb[c] = 0;
    end
    for (int i = LAT-1; i > 0; i--) mdl[c][i] = mdl[c][i-1];
    mdl[c][0] = mb[c];
  endtask

  task automatic samp(int x0, int x1, string tag);
    model_step(0, x0, tag);
    model_step(1, x1, tag);
    s_data  = {SW'(x1), SW'(x0)};
    s_valid = 2'b11;
    @(negedge clk);
    s_valid = '0;
    for (int c = 0; c < NUM_CH; c++)
      chk({tag, " again"}, int'(again[c*4 +: 4]), is_act(c) ? mb[c] : 0);
  endtask

  task automatic set_ctrl(logic p, logic r, logic [NUM_CH-1:0] en);
    pw = p; rate_hi = r; ch_en = en;
    for (int c = 0; c < NUM_CH; c++) if (!is_act(c)) model_clear(c);
    @(negedge clk);
  endtask

  task automatic cfgw(int t, int m, int h);
    cfg_thr = 4'(t); cfg_max = 4'(m); cfg_hold = HOLD_W'(h); cfg_we = 1'b1;
    if (!pw) begin
      if (t > 9 || m > 14) m_err = 1;
      m_thr  = (t > 9) ? 7 : t;
      m_max  = (m > 14) ? 11 : m;
      m_hold = h;
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // monitor: pop expected compensated words as they emerge
  always @(negedge clk) begin
    if (rst_n) begin
      if (o_valid[0]) begin
        if (exp0.size() == 0) chk("R6 ch0 unexpected output", 1, 0);
        else chk({tag0.pop_front(), " R6 ch0 data"}, int'($signed(o_data[0 +: SW])), exp0.pop_front());
      end
      if (o_valid[1]) begin
        if (exp1.size() == 0) chk("R6 ch1 unexpected output", 1, 0);
        else chk({tag1.pop_front(), " R6 ch1 data"}, int'($signed(o_data[SW +: SW])), exp1.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < NUM_CH; c++) model_clear(c);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 again reset", int'(again), 0);
    chk("R1 out_valid reset", int'(o_valid), 0);
    chk("R1 err reset", int'(cfg_err), 0);

    // R1: default trigger (64) and hold (16) give one step after 16 quiet samples
    set_ctrl(1'b1, 1'b0, 2'b11);
    for (int i = 0; i < 17; i++) samp(10, -10, "R1 defaults");
    chk("R1 boost after defaults", int'(again[3:0]), 1);

    // R3 R4 R2: trigger 9 (16), cap 2 steps, hold 3, ch1 disabled
    set_ctrl(1'b0, 1'b0, 2'b11);
    cfgw(9, 1, 3);
    set_ctrl(1'b1, 1'b0, 2'b01);
    for (int i = 0; i < 8; i++) samp(5, 1000, "R3 R4 R2 quiet");
    chk("R4 cap 2", int'(again[3:0]), 2);
    chk("R2 disabled again", int'(again[7:4]), 0);

    // R5: loud sample releases at once
    samp(20000, -1234, "R5 release");
    chk("R5 released", int'(again[3:0]), 0);

    // R7: writes while powered are ignored
    cfgw(0, 14, 1);
    for (int i = 0; i < 9; i++) samp(5, 7, "R7 locked");
    chk("R7 cap unchanged", int'(again[3:0]), 2);
    chk("R7 err unchanged", int'(cfg_err), 0);

    // R8: reserved codes fall back to defaults and set the flag
    set_ctrl(1'b0, 1'b0, 2'b11);
    cfgw(12, 15, 2);
    chk("R8 err set", int'(cfg_err), 1);
    set_ctrl(1'b1, 1'b0, 2'b11);
    for (int i = 0; i < 26; i++) samp(40, -40, "R8 R4 climb");
    chk("R4 cap 12 ch0", int'(again[3:0]), 12);
    chk("R4 cap 12 ch1", int'(again[7:4]), 12);
    samp(3000, 5, "R5 release at cap");
    for (int i = 0; i < 4; i++) samp(40, 40, "R6 delayed comp");
    cfgw(0, 0, 0);
    chk("R8 err sticky", int'(cfg_err), 1);

    // R9: high sample rate forces the function off
    set_ctrl(1'b1, 1'b1, 2'b11);
    chk("R9 again off", int'(again), 0);
    for (int i = 0; i < 3; i++) samp(-300, 300, "R9 passthrough");
    set_ctrl(1'b1, 1'b0, 2'b11);
    for (int i = 0; i < 5; i++) samp(20, -20, "R9 restart");

    repeat (3) @(negedge clk);
    chk("R6 queues drained", exp0.size() + exp1.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule